// File: doc/BRIEF.md
# I2C Slave Byte Memory with Page Staging

This block is a two-wire bus slave in front of a byte-wide memory. A fast system clock oversamples the bus clock and data lines through a short synchronizer. The block finds START and STOP conditions and recognizes its own 7-bit device address, which is a fixed `1010` prefix followed by three strap pins. It then takes a two-byte word address and either stages written bytes in a page buffer or streams bytes back to the master. The data line is open drain: the block only ever asserts an output enable that pulls the line low.

Written bytes collect in a staging buffer of `2**PAGE_W` entries (64 by default) and reach the memory only when the master ends the transfer with a STOP. The commit then walks the buffer in `2**PAGE_W` system clock cycles. During that window a new device address is not acknowledged, so a master can poll for completion. A write-protect input suppresses every change to the memory. Memory depth is `2**ADDR_W` bytes. The full-size part uses `ADDR_W = 14`, and the default is 11 to keep elaboration small.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: While `rst` is high and after it falls, `sda_oe_o` is 0 (line released) until a START is followed by a matching device address.
- R2: A falling data line while the clock is high is a START, and a rising data line while the clock is high is a STOP. Bytes clocked without a preceding START get no acknowledge.
- R3: The device byte is `1010`, then `strap_i[2:0]` (bit 2 first), then the read flag. If the middle three bits differ from the strap pins, the block does not acknowledge and stays silent until the next START.
- R4: The block acknowledges by pulling the data line low on the 9th clock after a matching device byte, after each of the two word-address bytes, and after each write data byte.
- R5: The word address is sent high byte first. Only its low `ADDR_W` bits select a location.
- R6: During a write, each data byte goes to the current address, and then only the low `PAGE_W` address bits increment, wrapping inside the current page.
- R7: Staged bytes reach memory only after a STOP. A START that arrives before the STOP discards them.
- R8: While `wp_i` is 1, no byte in the memory changes.
- R9: In a read, the address increments after each byte sent and wraps from the last location to 0. A master acknowledge (data low) continues the read. A master no-acknowledge ends it, and the line stays released.
- R10: A repeated START after the word address, followed by a device byte with read flag 1, returns data starting at that word address.
- R11: For `2**PAGE_W` system clock cycles after a STOP that commits staged bytes, a device byte gets no acknowledge. After that window it is acknowledged again.
- R12: Read data goes out most significant bit first. Each bit is placed after a falling edge of the bus clock, and `sda_oe_o` = 1 means "drive low", i.e. bit value 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| strap_i | input | 3 | Device address select pins |
| wp_i | input | 1 | Write protect, 1 blocks all memory writes |
| sda_oe_o | output | 1 | Open-drain enable, 1 pulls the data line low |

## Verification
The page commit and the acknowledge decision for a new device byte can fall into the same span of system cycles. A START that arrives mid-commit must neither corrupt the commit nor receive an acknowledge. The bench provokes this by issuing a STOP after a staged write and then, at once, a START and a device byte with compressed bus timing, so that the ninth clock lands inside the commit window. It judges the result from the acknowledge bit it samples: high inside the window, low once the window has passed. A later read-back shows that the committed byte survived the overlapping START.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  localparam logic [3:0] DEV_PREFIX = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WR,
    ST_RD
  } link_st_e;
endpackage

// File: rtl/i2c_bus_sense.sv
module i2c_bus_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt,
  output logic sda_lvl
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] scl_sh, sda_sh;
  logic         scl_d, sda_d;
  logic         scl_now, sda_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[MSB-1:0], scl_i};
      sda_sh <= {sda_sh[MSB-1:0], sda_i};
      scl_d  <= scl_sh[MSB];
      sda_d  <= sda_sh[MSB];
    end
  end

  assign scl_now   = scl_sh[MSB];
  assign sda_now   = sda_sh[MSB];
  assign sda_lvl   = sda_now;
  assign scl_rise  = scl_now & ~scl_d;
  assign scl_fall  = ~scl_now & scl_d;
  // data edges only count as conditions while the clock stays high
  assign start_evt = scl_now & scl_d & sda_d & ~sda_now;
  assign stop_evt  = scl_now & scl_d & ~sda_d & sda_now;
endmodule

// File: rtl/i2c_link_fsm.sv
module i2c_link_fsm
  import i2c_mem_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              sda_lvl,
  input  logic [2:0]        strap_i,
  input  logic              busy_i,
  input  logic [7:0]        rd_data_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              buf_wr_o,
  output logic [PAGE_W-1:0] buf_idx_o,
  output logic [7:0]        buf_data_o,
  output link_st_e          st_o,
  output logic              ack_ph_o
);
  link_st_e          st_q;
  logic              ack_ph_q;
  logic [3:0]        cnt_q;
  logic [7:0]        sh_q, tx_q, hi_q;
  logic              rw_q, mack_q, oe_q;
  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      ack_ph_q   <= 1'b0;
      cnt_q      <= '0;
      sh_q       <= '0;
      tx_q       <= '0;
      hi_q       <= '0;
      rw_q       <= 1'b0;
      mack_q     <= 1'b1;
      oe_q       <= 1'b0;
      ptr_q      <= '0;
      buf_wr_o   <= 1'b0;
      buf_idx_o  <= '0;
      buf_data_o <= '0;
    end else begin
      buf_wr_o <= 1'b0;
      if (start_evt) begin
        st_q     <= ST_DEV;
        ack_ph_q <= 1'b0;
        cnt_q    <= '0;
        oe_q     <= 1'b0;
      end else if (stop_evt) begin
        st_q     <= ST_IDLE;
        ack_ph_q <= 1'b0;
        cnt_q    <= '0;
        oe_q     <= 1'b0;
      end else if (st_q == ST_RD) begin
        if (!ack_ph_q) begin
          if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              oe_q     <= 1'b0;
              ack_ph_q <= 1'b1;
              ptr_q    <= ptr_q + ADDR_W'(1);
            end else begin
              oe_q  <= ~tx_q[7];
              tx_q  <= {tx_q[6:0], 1'b0};
              cnt_q <= cnt_q + 4'd1;
            end
          end
        end else begin
          if (scl_rise) mack_q <= sda_lvl;
          if (scl_fall) begin
            ack_ph_q <= 1'b0;
            if (!mack_q) begin
              oe_q  <= ~rd_data_i[7];
              tx_q  <= {rd_data_i[6:0], 1'b0};
              cnt_q <= 4'd1;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
      end else if (st_q != ST_IDLE) begin
        if (!ack_ph_q) begin
          if (scl_rise && cnt_q != 4'd8) begin
            sh_q  <= {sh_q[6:0], sda_lvl};
            cnt_q <= cnt_q + 4'd1;
          end
          if (scl_fall && cnt_q == 4'd8) begin
            case (st_q)
              ST_DEV: begin
                if (sh_q[7:1] == {DEV_PREFIX, strap_i} && !busy_i) begin
                  oe_q     <= 1'b1;
                  ack_ph_q <= 1'b1;
                  rw_q     <= sh_q[0];
                end else begin
                  st_q <= ST_IDLE;
                end
              end
              ST_AHI: begin
                hi_q     <= sh_q;
                oe_q     <= 1'b1;
                ack_ph_q <= 1'b1;
              end
              ST_ALO: begin
                ptr_q    <= ADDR_W'({hi_q, sh_q});
                oe_q     <= 1'b1;
                ack_ph_q <= 1'b1;
              end
              ST_WR: begin
                buf_wr_o   <= 1'b1;
                buf_idx_o  <= ptr_q[PAGE_W-1:0];
                buf_data_o <= sh_q;
                ptr_q[PAGE_W-1:0] <= ptr_q[PAGE_W-1:0] + PAGE_W'(1);
                oe_q       <= 1'b1;
                ack_ph_q   <= 1'b1;
              end
              default: st_q <= ST_IDLE;
            endcase
          end
        end else if (scl_fall) begin
          ack_ph_q <= 1'b0;
          cnt_q    <= '0;
          oe_q     <= 1'b0;
          case (st_q)
            ST_DEV: begin
              if (rw_q) begin
                st_q  <= ST_RD;
                oe_q  <= ~rd_data_i[7];
                tx_q  <= {rd_data_i[6:0], 1'b0};
                cnt_q <= 4'd1;
              end else begin
                st_q <= ST_AHI;
              end
            end
            ST_AHI:  st_q <= ST_ALO;
            ST_ALO:  st_q <= ST_WR;
            default: ;
          endcase
        end
      end
    end
  end

  assign sda_oe_o = oe_q;
  assign ptr_o    = ptr_q;
  assign st_o     = st_q;
  assign ack_ph_o = ack_ph_q;
endmodule

// File: rtl/i2c_page_stage.sv
module i2c_page_stage #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wp_i,
  input  logic                     wr_i,
  input  logic [PAGE_W-1:0]        idx_i,
  input  logic [7:0]               data_i,
  input  logic                     clear_i,
  input  logic                     stop_i,
  input  logic [ADDR_W-PAGE_W-1:0] page_i,
  output logic                     busy_o,
  output logic                     mem_we_o,
  output logic [ADDR_W-1:0]        mem_waddr_o,
  output logic [7:0]               mem_wdata_o
);
  localparam int DEPTH = 1 << PAGE_W;
  localparam int PG_W  = ADDR_W - PAGE_W;

  logic [7:0]        stage [DEPTH];
  logic [DEPTH-1:0]  vld_q;
  logic              active_q;
  logic [PAGE_W-1:0] cidx_q;
  logic [PG_W-1:0]   cpage_q;

  always_ff @(posedge clk) begin
    if (wr_i && !wp_i && !active_q) stage[idx_i] <= data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q    <= '0;
      active_q <= 1'b0;
      cidx_q   <= '0;
      cpage_q  <= '0;
    end else if (active_q) begin
      if (wp_i) begin
        active_q <= 1'b0;
        vld_q    <= '0;
      end else begin
        cidx_q <= cidx_q + PAGE_W'(1);
        if (&cidx_q) begin
          active_q <= 1'b0;
          vld_q    <= '0;
        end
      end
    end else if (stop_i && (|vld_q) && !wp_i) begin
      active_q <= 1'b1;
      cidx_q   <= '0;
      cpage_q  <= page_i;
    end else if (stop_i || clear_i) begin
      vld_q <= '0;
    end else if (wr_i && !wp_i) begin
      vld_q[idx_i] <= 1'b1;
    end
  end

  assign busy_o      = active_q;
  assign mem_we_o    = active_q & vld_q[cidx_q];
  assign mem_waddr_o = {cpage_q, cidx_q};
  assign mem_wdata_o = stage[cidx_q];
endmodule

// File: rtl/i2c_byte_ram.sv
module i2c_byte_ram #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) cells[waddr_i] <= wdata_i;
    rdata_o <= cells[raddr_i];
  end
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import i2c_mem_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int PAGE_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_oe_o
);
  logic              scl_rise_w, scl_fall_w, start_w, stop_w, sda_lvl_w;
  logic              busy_w, buf_wr_w, mem_we_w, ack_ph_w;
  logic [PAGE_W-1:0] buf_idx_w;
  logic [7:0]        buf_data_w, rd_data_w, mem_wdata_w;
  logic [ADDR_W-1:0] ptr_w, mem_waddr_w;
  link_st_e          st_w;

  i2c_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise_w), .scl_fall(scl_fall_w),
    .start_evt(start_w), .stop_evt(stop_w), .sda_lvl(sda_lvl_w)
  );

  i2c_link_fsm #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_fsm (
    .clk(clk), .rst(rst), .scl_rise(scl_rise_w), .scl_fall(scl_fall_w),
    .start_evt(start_w), .stop_evt(stop_w), .sda_lvl(sda_lvl_w),
    .strap_i(strap_i), .busy_i(busy_w), .rd_data_i(rd_data_w),
    .sda_oe_o(sda_oe_o), .ptr_o(ptr_w), .buf_wr_o(buf_wr_w),
    .buf_idx_o(buf_idx_w), .buf_data_o(buf_data_w),
    .st_o(st_w), .ack_ph_o(ack_ph_w)
  );

  i2c_page_stage #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_stage (
    .clk(clk), .rst(rst), .wp_i(wp_i), .wr_i(buf_wr_w),
    .idx_i(buf_idx_w), .data_i(buf_data_w), .clear_i(start_w),
    .stop_i(stop_w), .page_i(ptr_w[ADDR_W-1:PAGE_W]),
    .busy_o(busy_w), .mem_we_o(mem_we_w),
    .mem_waddr_o(mem_waddr_w), .mem_wdata_o(mem_wdata_w)
  );

  i2c_byte_ram #(.ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .we_i(mem_we_w), .waddr_i(mem_waddr_w),
    .wdata_i(mem_wdata_w), .raddr_i(ptr_w), .rdata_o(rd_data_w)
  );
endmodule

// File: rtl/i2c_eeprom_checker.sv
module i2c_eeprom_checker
  import i2c_mem_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 6
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     oe,
  input logic                     start_evt,
  input logic                     stop_evt,
  input link_st_e                 st,
  input logic                     ack_ph,
  input logic                     busy,
  input logic                     wp,
  input logic                     mem_we,
  input logic [ADDR_W-PAGE_W-1:0] mem_page
);
  assert_reset_release_R1: assert property (@(posedge clk) rst |=> !oe)
    else $error("R1 line driven after reset");

  assert_start_rearm_R2: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> (st == ST_DEV && !oe))
    else $error("R2 START did not rearm address phase");

  assert_commit_after_stop_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop_evt))
    else $error("R7 commit began without STOP");

  assert_wp_guard_R8: assert property (@(posedge clk) disable iff (rst)
    wp |=> !mem_we)
    else $error("R8 memory written under write protect");

  assert_page_confined_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> mem_page == $past(mem_page))
    else $error("R6 commit left its page");

  assert_busy_nack_R11: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DEV && ack_ph) |-> !busy)
    else $error("R11 device acknowledged during commit");

  assert_drive_context_R12: assert property (@(posedge clk) disable iff (rst)
    oe |-> (ack_ph || st == ST_RD))
    else $error("R12 line driven outside ack or read");
endmodule

bind i2c_eeprom_slave i2c_eeprom_checker #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst(rst), .oe(sda_oe_o), .start_evt(start_w), .stop_evt(stop_w),
  .st(st_w), .ack_ph(ack_ph_w), .busy(busy_w), .wp(wp_i), .mem_we(mem_we_w),
  .mem_page(mem_waddr_w[ADDR_W-1:PAGE_W])
);

// File: tb/i2c_eeprom_slave_bench.sv
module i2c_eeprom_slave_bench;
  logic       clk = 1'b0, rst = 1'b1, scl = 1'b1, m_sda = 1'b1, wp = 1'b0;
  logic [2:0] strap = 3'b101;
  logic       sda_oe;
  logic       sda_bus;
  int         checks = 0, errors = 0, hp = 8;

  localparam logic [7:0] DEV_W = 8'hAA;
  localparam logic [7:0] DEV_R = 8'hAB;
  // {word address, data, write protect, expected read-back}
  localparam logic [32:0] VEC [6] = '{
    {16'h0010, 8'h5A, 1'b0, 8'h5A},
    {16'h0010, 8'hA5, 1'b1, 8'h5A},
    {16'h07FF, 8'h3C, 1'b0, 8'h3C},
    {16'hC123, 8'h77, 1'b0, 8'h77},
    {16'h0040, 8'h00, 1'b0, 8'h00},
    {16'h0555, 8'hFF, 1'b0, 8'hFF}
  };

  assign sda_bus = m_sda & ~sda_oe;
  always #2 clk = ~clk;

  i2c_eeprom_slave u_i2c_eeprom_slave (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus),
    .strap_i(strap), .wp_i(wp), .sda_oe_o(sda_oe)
  );

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wt(hp);
    scl = 1'b1;   wt(hp);
    m_sda = 1'b0; wt(hp);
    scl = 1'b0;   wt(1);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wt(hp);
    scl = 1'b1;   wt(hp);
    m_sda = 1'b1; wt(hp);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wt(hp);
      scl = 1'b1;   wt(hp);
      scl = 1'b0;   wt(1);
    end
    m_sda = 1'b1; wt(8);
    scl = 1'b1;   wt(4);
    ack = sda_bus; wt(4);
    scl = 1'b0;   wt(1);
  endtask

  task automatic read_byte(input logic nack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; wt(hp);
      scl = 1'b1;   wt(hp / 2);
      b[i] = sda_bus; wt(hp / 2);
      scl = 1'b0;   wt(1);
    end
    m_sda = nack; wt(hp);
    scl = 1'b1;   wt(hp);
    scl = 1'b0;   wt(1);
    m_sda = 1'b1;
  endtask

  task automatic write_seq(input logic [15:0] a, input int n, input logic [31:0] d,
                           input logic stop_en);
    logic ack;
    bus_start();
    send_byte(DEV_W, ack);    chk({31'd0, ack}, 0, "R4 device ack on write");
    send_byte(a[15:8], ack);  chk({31'd0, ack}, 0, "R4 high address ack");
    send_byte(a[7:0], ack);   chk({31'd0, ack}, 0, "R4 low address ack");
    for (int i = 0; i < n; i++) begin
      send_byte(d[8*i +: 8], ack);
      chk({31'd0, ack}, 0, "R4 data byte ack");
    end
    if (stop_en) bus_stop();
  endtask

  task automatic read_seq(input logic [15:0] a, input int n, output logic [31:0] got);
    logic       ack;
    logic [7:0] b;
    got = '0;
    bus_start();
    send_byte(DEV_W, ack);    chk({31'd0, ack}, 0, "R4 device ack before read");
    send_byte(a[15:8], ack);  chk({31'd0, ack}, 0, "R5 high address ack");
    send_byte(a[7:0], ack);   chk({31'd0, ack}, 0, "R5 low address ack");
    bus_start();
    send_byte(DEV_R, ack);    chk({31'd0, ack}, 0, "R10 read device ack after repeated START");
    for (int i = 0; i < n; i++) begin
      read_byte(i == n - 1, b);
      got[8*i +: 8] = b;
    end
    bus_stop();
  endtask

  logic [15:0] va;
  logic [7:0]  vd, ve;
  logic        vw, ack_b;
  logic [31:0] got;

  initial begin
    wt(5);
    chk({31'd0, sda_oe}, 0, "R1 released in reset");
    rst = 1'b0;
    wt(5);
    chk({31'd0, sda_oe}, 0, "R1 released after reset");

    // bytes clocked with no START
    scl = 1'b0; wt(hp);
    send_byte(DEV_W, ack_b);
    chk({31'd0, ack_b}, 1, "R2 no ack without START");
    m_sda = 1'b1; wt(hp); scl = 1'b1; wt(20);

    // table of single-byte writes and read-backs
    for (int i = 0; i < 6; i++) begin
      {va, vd, vw, ve} = VEC[i];
      wp = vw;
      write_seq(va, 1, {24'd0, vd}, 1'b1);
      wt(4);
      wp = 1'b0;
      wt(80);
      read_seq(va, 1, got);
      chk({24'd0, got[7:0]}, {24'd0, ve}, "R5 R8 R12 table read-back");
    end

    // upper address bits ignored
    read_seq(16'h0123, 1, got);
    chk({24'd0, got[7:0]}, 32'h77, "R5 truncated address alias");

    // wrong strap bits
    bus_start();
    send_byte(8'hA2, ack_b); chk({31'd0, ack_b}, 1, "R3 mismatched device byte");
    send_byte(8'h00, ack_b); chk({31'd0, ack_b}, 1, "R3 silent until START");
    bus_stop();
    strap = 3'b001;
    bus_start();
    send_byte(8'hA2, ack_b); chk({31'd0, ack_b}, 0, "R3 strap pins select address");
    bus_stop();
    strap = 3'b101;
    wt(20);

    // page write wrapping inside its page
    write_seq(16'h003E, 4, 32'h44332211, 1'b1);
    wt(80);
    read_seq(16'h003E, 2, got);
    chk({16'd0, got[15:0]}, 32'h2211, "R6 bytes before page wrap");
    read_seq(16'h0000, 2, got);
    chk({16'd0, got[15:0]}, 32'h4433, "R6 bytes after page wrap");
    read_seq(16'h0040, 1, got);
    chk({24'd0, got[7:0]}, 32'h00, "R6 next page untouched");

    // sequential read wrap
    read_seq(16'h07FF, 2, got);
    chk({16'd0, got[15:0]}, 32'h333C, "R9 read wraps to location 0");
    chk({31'd0, sda_oe}, 0, "R9 line released after master NACK");

    // START before STOP discards staged data
    write_seq(16'h0200, 1, 32'h12, 1'b1);
    wt(80);
    write_seq(16'h0200, 1, 32'h99, 1'b0);
    read_seq(16'h0200, 1, got);
    chk({24'd0, got[7:0]}, 32'h12, "R7 repeated START drops staged byte");
    wt(80);
    read_seq(16'h0200, 1, got);
    chk({24'd0, got[7:0]}, 32'h12, "R7 no late commit");

    // acknowledge polling during commit
    write_seq(16'h0300, 1, 32'h5C, 1'b0);
    hp = 1;
    bus_stop();
    bus_start();
    send_byte(DEV_W, ack_b);
    chk({31'd0, ack_b}, 1, "R11 device NACK during commit");
    bus_stop();
    hp = 8;
    wt(100);
    bus_start();
    send_byte(DEV_W, ack_b);
    chk({31'd0, ack_b}, 0, "R11 device ACK after commit");
    bus_stop();
    wt(20);
    read_seq(16'h0300, 1, got);
    chk({24'd0, got[7:0]}, 32'h5C, "R7 R11 commit survived overlapping START");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule